// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each data beat of a double-data-rate memory read or write burst. Software or a controller fixes the burst before it starts. It supplies a start column, a 3-bit length code and an ordering select. Once a burst starts, the block presents one column per beat. Each beat carries two data words, one on each clock edge, so the column moves by two for every beat that the consumer accepts with `advance_i`.

Fixed bursts of 2, 4 and 8 words wrap inside their aligned block, in either sequential or interleaved order. A full-page burst walks the whole 256-column row in sequential order. It wraps past the top of the row and keeps going until `stop_i` ends it. A start with an illegal setting raises the error flag and starts no burst.

The control is a three-state machine:
- `ST_IDLE`: no burst is active.
- `ST_FIXED`: a 2, 4 or 8 word burst is in progress.
- `ST_PAGE`: a full-page burst is in progress.

The transitions are:
- IDLE to FIXED or PAGE, on a legal start.
- Any state to IDLE, on an illegal start.
- Any state to FIXED or PAGE, on a legal start. A start during a burst aborts that burst and reloads.
- FIXED or PAGE to IDLE, on stop.
- FIXED to IDLE, when the last beat is advanced.
- FIXED to FIXED and PAGE to PAGE, on advance, with the beat count incremented.

Priority from highest to lowest is start, then stop, then advance.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `err_o` are 0.
- R2: A legal start presents the start column on `col_o` with `valid_o`=1 and `err_o`=0 in the cycle after the strobe.
- R3: The length code is 3'b001 for 2 words, 3'b010 for 4 words, 3'b011 for 8 words and 3'b111 for full page. On a start, any other code sets `err_o`=1 and leaves `valid_o`=0.
- R4: With `order_i`=0 (sequential) and burst length BL of 2, 4 or 8, beat k (counting from 0) has the same upper bits as the start column. Its low log2(BL) bits are (start + 2k) mod BL. The burst has BL/2 beats.
- R5: With `order_i`=1 (interleaved) and BL of 2, 4 or 8, beat k is the start column with its low log2(BL) bits XORed with 2k.
- R6: In a full-page burst, beat k is (start + 2k) mod 256. The burst continues past the wrap from 254 to 0 with `last_o`=0 until `stop_i` is asserted.
- R7: A full-page start with `order_i`=1 sets `err_o`=1 and starts no burst.
- R8: A full-page start with an odd start column sets `err_o`=1 and starts no burst.
- R9: `last_o` is 1 exactly on the final beat of a fixed burst. When that beat is advanced, `valid_o` is 0 in the next cycle.
- R10: While `advance_i`=0, `col_o` and `valid_o` hold.
- R11: A start during an active burst takes priority over advance. In the next cycle it presents the new burst's first column, and the old burst ends.
- R12: When `stop_i` is asserted without a start, `valid_o` is 0 in the next cycle.
- R13: `err_o` holds until the next start. An illegal start during a burst ends that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe for a burst |
| start_col_i | input | 8 | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 selects sequential order, 1 selects interleaved order |
| advance_i | input | 1 | Consumes the current beat |
| stop_i | input | 1 | Ends the current burst |
| col_o | output | 8 | Column for the current beat |
| valid_o | output | 1 | A beat is presented |
| last_o | output | 1 | The current beat is the final one of a fixed burst |
| err_o | output | 1 | The most recent start had an illegal setting |

## Verification
The two functions that can land in the same cycle are an advance of the current beat and a new start strobe. This collision is provoked by raising `start_i` while `advance_i` is still high in the middle of an 8-word burst. The scoreboard expects the old beat that was on display in that cycle. After it, the scoreboard expects only the new burst's columns, and any leftover beat of the old burst shows up as a mismatch. A second collision, an illegal start arriving mid-burst, is judged by `valid_o` dropping while `err_o` rises.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIXED = 2'd1,
        ST_PAGE  = 2'd2
    } seq_state_t;

    localparam int LEN_CODE_W = 3;

    localparam logic [LEN_CODE_W-1:0] LEN_BL2  = 3'b001;
    localparam logic [LEN_CODE_W-1:0] LEN_BL4  = 3'b010;
    localparam logic [LEN_CODE_W-1:0] LEN_BL8  = 3'b011;
    localparam logic [LEN_CODE_W-1:0] LEN_PAGE = 3'b111;

endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 8,
    parameter int LG_W  = $clog2(COL_W) + 1
) (
    input  logic [LEN_CODE_W-1:0] code_i,
    input  logic                  order_i,
    input  logic                  col_lsb_i,
    output logic                  legal_o,
    output logic                  page_o,
    output logic [LG_W-1:0]       lg_o
);

    always_comb begin
        legal_o = 1'b1;
        page_o  = 1'b0;
        lg_o    = '0;
        case (code_i)
            LEN_BL2:  lg_o = LG_W'(1);
            LEN_BL4:  lg_o = LG_W'(2);
            LEN_BL8:  lg_o = LG_W'(3);
            LEN_PAGE: begin
                page_o  = 1'b1;
                lg_o    = LG_W'(COL_W);
                // page mode needs sequential order and an even start
                legal_o = !order_i && !col_lsb_i;
            end
            default:  legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
    parameter int COL_W  = 8,
    parameter int LG_W   = $clog2(COL_W) + 1,
    parameter int STEP_W = COL_W - 1
) (
    input  logic [COL_W-1:0]  base_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [LG_W-1:0]   lg_i,
    input  logic              order_i,
    input  logic              page_i,
    output logic [COL_W-1:0]  col_o
);

    logic [COL_W-1:0] offset;
    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] sum;

    always_comb begin
        offset = {step_i, 1'b0};
        mask   = (COL_W'(1) << lg_i) - COL_W'(1);
        sum    = base_i + offset;
        if (page_i) begin
            col_o = sum;
        end else if (order_i) begin
            col_o = base_i ^ (offset & mask);
        end else begin
            col_o = (base_i & ~mask) | (sum & mask);
        end
    end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  order_i,
    input  logic                  advance_i,
    input  logic                  stop_i,
    output logic [COL_W-1:0]      col_o,
    output logic                  valid_o,
    output logic                  last_o,
    output logic                  err_o
);

    localparam int LG_W   = $clog2(COL_W) + 1;
    localparam int STEP_W = COL_W - 1;

    seq_state_t        state_q, state_n;
    logic [COL_W-1:0]  base_q, base_n;
    logic [STEP_W-1:0] step_q, step_n;
    logic [LG_W-1:0]   lg_q, lg_n;
    logic              ord_q, ord_n;
    logic              err_q, err_n;

    logic              dec_legal;
    logic              dec_page;
    logic [LG_W-1:0]   dec_lg;
    logic [COL_W-1:0]  gen_col;
    logic [STEP_W-1:0] beats_m1;
    logic              on_last;

    burst_len_decode #(.COL_W(COL_W), .LG_W(LG_W)) u_dec (
        .code_i    (len_code_i),
        .order_i   (order_i),
        .col_lsb_i (start_col_i[0]),
        .legal_o   (dec_legal),
        .page_o    (dec_page),
        .lg_o      (dec_lg)
    );

    burst_col_gen #(.COL_W(COL_W), .LG_W(LG_W), .STEP_W(STEP_W)) u_gen (
        .base_i  (base_q),
        .step_i  (step_q),
        .lg_i    (lg_q),
        .order_i (ord_q),
        .page_i  (state_q == ST_PAGE),
        .col_o   (gen_col)
    );

    // a fixed burst of BL words has BL/2 beats
    assign beats_m1 = (STEP_W'(1) << (lg_q - LG_W'(1))) - STEP_W'(1);
    assign on_last  = (state_q == ST_FIXED) && (step_q == beats_m1);

    // next-state and datapath loading
    always_comb begin
        state_n = state_q;
        base_n  = base_q;
        step_n  = step_q;
        lg_n    = lg_q;
        ord_n   = ord_q;
        err_n   = err_q;
        if (start_i) begin
            err_n = !dec_legal;
            if (dec_legal) begin
                state_n = dec_page ? ST_PAGE : ST_FIXED;
                base_n  = start_col_i;
                step_n  = '0;
                lg_n    = dec_lg;
                ord_n   = order_i;
            end else begin
                state_n = ST_IDLE;
            end
        end else if (stop_i) begin
            state_n = ST_IDLE;
        end else if (advance_i) begin
            unique case (state_q)
                ST_FIXED: begin
                    if (on_last) state_n = ST_IDLE;
                    else         step_n  = step_q + STEP_W'(1);
                end
                ST_PAGE:  step_n = step_q + STEP_W'(1);
                default:  state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            step_q  <= '0;
            lg_q    <= LG_W'(1);
            ord_q   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_n;
            base_q  <= base_n;
            step_q  <= step_n;
            lg_q    <= lg_n;
            ord_q   <= ord_n;
            err_q   <= err_n;
        end
    end

    // outputs
    always_comb begin
        valid_o = (state_q != ST_IDLE);
        last_o  = on_last;
        col_o   = valid_o ? gen_col : '0;
        err_o   = err_q;
    end

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic [2:0]       len_code_i,
    input logic             order_i,
    input logic             advance_i,
    input logic             stop_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             err_o
);

    AST_START_LOADS_COL: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!valid_o || col_o == $past(start_col_i))); // R2

    AST_PAGE_INTERLEAVE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && len_code_i == 3'b111 && order_i) |=> (err_o && !valid_o)); // R7

    AST_PAGE_ODD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && len_code_i == 3'b111 && start_col_i[0]) |=> (err_o && !valid_o)); // R8

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R9

    AST_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && advance_i && !start_i) |=> !valid_o); // R9

    AST_HOLD_WITHOUT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !advance_i && !start_i && !stop_i) |=> (valid_o && $stable(col_o))); // R10

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> !valid_o); // R12

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(err_o)); // R13

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sim_burst_col_seq.sv
module sim_burst_col_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] start_col_i = '0;
    logic [2:0] len_code_i = '0;
    logic       order_i = 1'b0;
    logic       advance_i = 1'b0;
    logic       stop_i = 1'b0;
    logic [7:0] col_o;
    logic       valid_o, last_o, err_o;

    int checks = 0;
    int errors = 0;
    logic [8:0] expq[$];   // {last, col}

    always #2 clk = ~clk;   // 250 MHz

    burst_col_seq u0 (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected column from the requirement formulas (R4 R5 R6)
    function automatic logic [7:0] exp_col(input logic [7:0] s, input int lg,
                                           input logic ord, input int k, input logic page);
        logic [7:0] msk, off;
        off = 8'(2 * k);
        if (page) return s + off;
        msk = 8'((1 << lg) - 1);
        if (ord) return s ^ (off & msk);
        return (s & ~msk) | ((s + off) & msk);
    endfunction

    // monitor: every accepted beat is popped and compared
    always @(negedge clk) begin
        if (rst_n && valid_o && advance_i) begin
            if (expq.size() == 0) begin
                checks++; errors++;
                $display("FAIL R4 actual=%0h expected=none (unexpected beat)", col_o);
            end else begin
                logic [8:0] e;
                e = expq.pop_front();
                check("R4/R5/R6/R9 beat", {last_o, col_o}, e);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_start(input logic [7:0] c, input logic [2:0] code, input logic ord);
        start_i = 1'b1; start_col_i = c; len_code_i = code; order_i = ord;
    endtask

    task automatic push_fixed(input logic [7:0] c, input int lg, input logic ord, input int from, input int upto);
        int beats = 1 << (lg - 1);
        for (int k = from; k < upto; k++)
            expq.push_back({(k == beats - 1), exp_col(c, lg, ord, k, 1'b0)});
    endtask

    task automatic run_fixed(input logic [7:0] c, input int lg, input logic ord);
        int beats = 1 << (lg - 1);
        push_fixed(c, lg, ord, 0, beats);
        tick(); do_start(c, 3'(lg), ord); advance_i = 1'b0;
        tick(); start_i = 1'b0; advance_i = 1'b1;
        @(negedge clk);
        check("R2 err clear", err_o, 0);
        check("R2 first col", col_o, c);
        repeat (beats) @(posedge clk);
        #1 advance_i = 1'b0;
        @(negedge clk);
        check("R9 valid drops", valid_o, 0);
    endtask

    task automatic try_illegal(input logic [7:0] c, input logic [2:0] code, input logic ord, input string req);
        tick(); do_start(c, code, ord);
        tick(); start_i = 1'b0;
        @(negedge clk);
        check(req, {err_o, valid_o}, 2'b10);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {valid_o, last_o, err_o}, 0);
        rst_n = 1'b1;

        // R4 sequential: 2, 4 and 8 words
        run_fixed(8'h35, 1, 1'b0);
        run_fixed(8'h13, 2, 1'b0);
        run_fixed(8'h2E, 3, 1'b0);
        // R5 interleaved
        run_fixed(8'h2E, 3, 1'b1);
        run_fixed(8'h13, 2, 1'b1);

        // R6 full page across the wrap, then R12 stop
        for (int k = 0; k < 4; k++) expq.push_back({1'b0, exp_col(8'hFC, 0, 1'b0, k, 1'b1)});
        tick(); do_start(8'hFC, 3'b111, 1'b0);
        tick(); start_i = 1'b0; advance_i = 1'b1;
        repeat (4) @(posedge clk);
        #1 advance_i = 1'b0;
        @(negedge clk);
        check("R6 still active", {valid_o, last_o, col_o}, {2'b10, 8'h04});
        tick(); stop_i = 1'b1;
        tick(); stop_i = 1'b0;
        @(negedge clk);
        check("R12 stop", valid_o, 0);

        // R7, R8, R3
        try_illegal(8'h10, 3'b111, 1'b1, "R7 page interleaved");
        try_illegal(8'h11, 3'b111, 1'b0, "R8 page odd");
        try_illegal(8'h10, 3'b000, 1'b0, "R3 code 000");
        try_illegal(8'h10, 3'b100, 1'b0, "R3 code 100");
        try_illegal(8'h10, 3'b110, 1'b1, "R3 code 110");

        // R13: err holds, then an illegal start ends an active burst
        tick(); do_start(8'h20, 3'b011, 1'b0);
        tick(); start_i = 1'b0;
        @(negedge clk);
        check("R13 err cleared by legal start", {err_o, valid_o}, 2'b01);
        tick(); do_start(8'h20, 3'b101, 1'b0);
        tick(); start_i = 1'b0;
        @(negedge clk);
        check("R13 illegal mid-burst", {err_o, valid_o}, 2'b10);
        repeat (2) tick();
        check("R13 err holds", err_o, 1);

        // R10 hold while advance low
        push_fixed(8'h2E, 3, 1'b0, 0, 4);
        tick(); do_start(8'h2E, 3'b011, 1'b0);
        tick(); start_i = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R10 hold", {valid_o, col_o}, {1'b1, 8'h2E});
        end
        tick(); advance_i = 1'b1;
        repeat (4) @(posedge clk);
        #1 advance_i = 1'b0;

        // R11 abort: start collides with advance mid-burst
        push_fixed(8'h40, 3, 1'b0, 0, 2);
        push_fixed(8'h81, 2, 1'b0, 0, 2);
        tick(); do_start(8'h40, 3'b011, 1'b0);
        tick(); start_i = 1'b0; advance_i = 1'b1;
        tick(); do_start(8'h81, 3'b010, 1'b0);
        tick(); start_i = 1'b0;
        @(negedge clk);
        check("R11 new burst first col", col_o, 8'h81);
        repeat (2) @(posedge clk);
        #1 advance_i = 1'b0;
        @(negedge clk);
        check("R11 old burst gone", valid_o, 0);

        tick();
        check("R4 scoreboard drained", expq.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule